// File: doc/BRIEF.md
# MDIO Register Command Engine

This block is a host-side engine for a PHY management port. Software reaches it through two 16-bit registers, one for control and one for data. Writing a control word that carries a read request or a write request starts one management transaction. The control word also names a PHY and a register inside that PHY. The engine then produces the management clock and shifts the complete serial frame out on the data line.

For a write, software first loads the 16-bit payload into the data register and then issues the control word. For a read, the engine releases the data line at the turnaround and shifts in sixteen bits from the PHY. When the frame ends, those bits replace the contents of the data register. The request bit that started the transaction stays set while the transaction runs, and the engine clears it itself at the end. Software therefore polls until both request bits read zero. The management clock divider is a parameter, so one transaction lasts a fixed, known number of system cycles. That number can be sized to stay far below a 10 ms software timeout.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the control register and the data register both read 0x0000.
- R2: The control word has a read request at bit 15, a write request at bit 14, the PHY register address in bits 12:8 and the PHY address in bits 4:0. A valid control write starts a transaction. The request bit that was set reads 1 while the transaction runs and reads 0 after it ends. The address fields read back as written.
- R3: A write transaction sends, MSB first: 32 ones, 01, 01, the PHY address, the register address, 10, and the 16 bits of the data register.
- R4: A read transaction sends 32 ones, 01, 10, the PHY address and the register address. The engine then drives nothing (mdio_oe_o low) for the remaining 18 bit times: 2 turnaround bits and 16 data bits.
- R5: During a read, the 16 bits present on mdio_i at the rising MDC edges after the turnaround are assembled MSB first. At completion they become the value of the data register.
- R6: MDC has a period of 2*DIV_HALF system cycles, and mdio_o changes only at MDC falling edges.
- R7: From the clock edge that accepts the command to the edge that clears the request bit, exactly 128*DIV_HALF system cycles pass (64 MDC periods).
- R8: While a transaction runs, writes to the control register and to the data register are ignored. The running frame and the register contents are unchanged.
- R9: A control word is ignored when it has neither request bit set, both request bits set, or any of bits 13 and 7:5 set. In that case no frame starts and the control register keeps its previous value.
- R10: While idle, MDC is held low and mdio_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 data |
| wdata_i | input | 16 | Host write data |
| rdata_o | output | 16 | Contents of the selected register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The case hardest to reach from the ports is a register write that lands in the middle of a running frame. The bench must show that such a write changes neither the bits already committed to the line nor the data register. To get there, the bench issues a command and, a few dozen cycles in, writes a different control word and a different payload. It then compares the full captured frame and the final register contents against the first command. A PHY model in the bench drives random read data after the turnaround, and random PHY and register addresses exercise every frame field.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       rsv_hi;
    logic [4:0] reg_a;
    logic [2:0] rsv_lo;
    logic [4:0] phy;
  } ctrl_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == CW'(DIV_HALF - 1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        op_read_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [5:0]           idx_q;
  logic                 busy_q;
  logic                 rd_q;
  logic [15:0]          shift_q;
  logic [FRAME_LEN-1:0] frame_w;

  // bit 63 leaves first
  assign frame_w = {{32{1'b1}}, 2'b01, rd_q ? 2'b10 : 2'b01, phy_i, reg_i,
                    rd_q ? 2'b00 : 2'b10, rd_q ? 16'h0000 : wdata_i};

  assign mdio_o    = busy_q && frame_w[~idx_q];
  assign mdio_oe_o = busy_q && !(rd_q && (idx_q >= 6'(TA_POS)));
  assign done_o    = busy_q && fall_i && (idx_q == 6'(FRAME_LEN - 1));
  assign busy_o    = busy_q;
  assign rdata_o   = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      shift_q <= '0;
    end else if (start_i && !busy_q) begin
      idx_q  <= '0;
      busy_q <= 1'b1;
      rd_q   <= op_read_i;
    end else if (busy_q) begin
      if (rise_i && rd_q && (idx_q >= 6'(DATA_POS)))
        shift_q <= {shift_q[14:0], mdio_i};
      if (fall_i) begin
        if (done_o) busy_q <= 1'b0;
        else        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  a_r6_mdio_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !fall_i) |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic        addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  ctrl_t       cmd;
  logic [4:0]  phy_q, reg_q;
  logic        rd_req_q, wr_req_q;
  logic [15:0] data_q;
  logic        busy, done, start, cmd_ok;
  logic        mdc_rise, mdc_fall;
  logic [15:0] rx_word;

  assign cmd    = ctrl_t'(wdata_i);
  assign cmd_ok = (cmd.rd ^ cmd.wr) && !cmd.rsv_hi && (cmd.rsv_lo == 3'b000);
  assign start  = wr_en_i && !addr_i && cmd_ok && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_q    <= '0;
      reg_q    <= '0;
      rd_req_q <= 1'b0;
      wr_req_q <= 1'b0;
      data_q   <= '0;
    end else begin
      if (start) begin
        phy_q    <= cmd.phy;
        reg_q    <= cmd.reg_a;
        rd_req_q <= cmd.rd;
        wr_req_q <= cmd.wr;
      end else if (done) begin
        rd_req_q <= 1'b0;
        wr_req_q <= 1'b0;
        if (rd_req_q) data_q <= rx_word;
      end
      if (wr_en_i && addr_i && !busy) data_q <= wdata_i;
    end
  end

  assign rdata_o = addr_i ? data_q
                          : {rd_req_q, wr_req_q, 1'b0, reg_q, 3'b000, phy_q};

  mdio_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (mdc_rise),
    .fall_o (mdc_fall)
  );

  mdio_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .op_read_i (cmd.rd),
    .phy_i     (phy_q),
    .reg_i     (reg_q),
    .wdata_i   (data_q),
    .rise_i    (mdc_rise),
    .fall_i    (mdc_fall),
    .mdio_i    (mdio_i),
    .busy_o    (busy),
    .done_o    (done),
    .rdata_o   (rx_word),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );

  a_r2_flags_track_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_q || wr_req_q) == busy);
  a_r2_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_q, wr_req_q}));
  a_r8_fields_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_en_i) |=> $stable({phy_q, reg_q}));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mdc_o && !mdio_oe_o));
endmodule

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 4;
  localparam int FRAME_CYC  = 128 * DIV_HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i;

  int checks = 0;
  int errors = 0;
  int cyc_now = 0;
  int nrise = 0, nfall = 0;
  int rise_base = 0, fall_base = 0;
  logic [15:0] phy_word = '0;
  logic        cap_o  [64];
  logic        cap_oe [64];
  int          t0;

  mdio_cmd_engine #(.DIV_HALF(DIV_HALF)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(posedge clk);
    cyc_now++;
  end

  // PHY model: captures on rising MDC, drives read data after falling MDC
  initial begin
    mdio_i = 1'b1;
    forever begin
      @(mdc);
      if (mdc) begin
        int k;
        k = nrise - rise_base;
        if (k >= 0 && k < 64) begin
          cap_o[k]  = mdio_o;
          cap_oe[k] = mdio_oe;
        end
        nrise++;
      end else begin
        int k;
        nfall++;
        k = nfall - fall_base;
        mdio_i = (k >= 48 && k <= 63) ? phy_word[63-k] : 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] phy,
                                            logic [4:0] rg, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
            rd ? 2'b00 : 2'b10, rd ? 16'h0000 : d};
  endfunction

  function automatic logic [15:0] ctrl_word(bit rd, logic [4:0] phy, logic [4:0] rg);
    return {rd, !rd, 1'b0, rg, 3'b000, phy};
  endfunction

  task automatic host_write(logic a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_cmd(bit rd, logic [4:0] phy, logic [4:0] rg,
                           logic [15:0] d, logic [15:0] pw);
    if (!rd) host_write(1'b1, d);
    phy_word  = pw;
    rise_base = nrise;
    fall_base = nfall;
    host_write(1'b0, ctrl_word(rd, phy, rg));
    t0 = cyc_now;
    addr = 1'b0;
    #1;
    check("R2 busy flag and fields", 64'(rdata), 64'(ctrl_word(rd, phy, rg)));
  endtask

  task automatic finish_cmd(bit rd, logic [4:0] phy, logic [4:0] rg,
                            logic [15:0] d, logic [15:0] pw);
    logic [63:0] ef;
    logic [63:0] got_o;
    logic [63:0] got_oe;
    logic [63:0] exp_oe;
    int guard;
    addr = 1'b0;
    guard = 0;
    @(negedge clk);
    while ((rdata[15] | rdata[14]) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check("R6 R7 transaction length", 64'(cyc_now - t0), 64'(FRAME_CYC));
    check("R2 flags clear, fields kept", 64'(rdata), 64'({3'b000, rg, 3'b000, phy}));
    check("R6 MDC rising edge count", 64'(nrise - rise_base), 64'd64);
    ef = exp_frame(rd, phy, rg, d);
    for (int i = 0; i < 64; i++) begin
      got_o[63-i]  = cap_oe[i] ? cap_o[i] : 1'b0;
      got_oe[63-i] = cap_oe[i];
    end
    exp_oe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    if (rd) begin
      check("R4 read frame header", got_o, ef);
      check("R4 release at turnaround", got_oe, exp_oe);
    end else begin
      check("R3 write frame", got_o, ef);
      check("R3 output enable whole frame", got_oe, exp_oe);
    end
    addr = 1'b1;
    #1;
    if (rd) check("R5 read data in data register", 64'(rdata), 64'(pw));
    else    check("R3 data register kept", 64'(rdata), 64'(d));
    addr = 1'b0;
  endtask

  task automatic run_cmd(bit rd, logic [4:0] phy, logic [4:0] rg,
                         logic [15:0] d, logic [15:0] pw);
    start_cmd(rd, phy, rg, d, pw);
    finish_cmd(rd, phy, rg, d, pw);
  endtask

  initial begin
    logic [15:0] last_ctrl;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 1'b0; #1;
    check("R1 control after reset", 64'(rdata), 64'h0);
    addr = 1'b1; #1;
    check("R1 data after reset", 64'(rdata), 64'h0);
    check("R10 idle MDC and enable", 64'({mdc, mdio_oe}), 64'h0);

    // directed corners
    run_cmd(1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0000);
    run_cmd(1'b1, 5'd0, 5'd0, 16'h0000, 16'hFFFF);
    run_cmd(1'b1, 5'd31, 5'd1, 16'h0000, 16'h8001);
    run_cmd(1'b0, 5'd0, 5'd0, 16'h0000, 16'h0000);

    // R8: writes while busy are ignored
    start_cmd(1'b0, 5'd5, 5'd9, 16'hA5C3, 16'h0);
    repeat (20) @(negedge clk);
    host_write(1'b0, ctrl_word(1'b1, 5'd17, 5'd22));
    host_write(1'b1, 16'h1234);
    addr = 1'b0; #1;
    check("R8 control unchanged while busy", 64'(rdata), 64'(ctrl_word(1'b0, 5'd5, 5'd9)));
    finish_cmd(1'b0, 5'd5, 5'd9, 16'hA5C3, 16'h0);

    start_cmd(1'b1, 5'd12, 5'd3, 16'h0, 16'h5A0F);
    repeat (100) @(negedge clk);
    host_write(1'b1, 16'hDEAD);
    host_write(1'b0, ctrl_word(1'b0, 5'd1, 5'd2));
    finish_cmd(1'b1, 5'd12, 5'd3, 16'h0, 16'h5A0F);

    // R9: invalid control words
    last_ctrl = {3'b000, 5'd3, 3'b000, 5'd12};
    foreach (last_ctrl[i]) begin end
    for (int v = 0; v < 4; v++) begin
      logic [15:0] bad;
      case (v)
        0: bad = 16'h0000 | 16'h0305;
        1: bad = 16'hC305;
        2: bad = 16'h6305;
        default: bad = 16'h8325;
      endcase
      host_write(1'b0, bad);
      repeat (4 * DIV_HALF) @(negedge clk);
      addr = 1'b0; #1;
      check("R9 invalid word ignored", 64'(rdata), 64'(last_ctrl));
      check("R9 R10 no frame started", 64'({mdc, mdio_oe}), 64'h0);
    end

    // random transactions
    for (int n = 0; n < 12; n++) begin
      bit rd;
      logic [4:0] phy, rg;
      logic [15:0] d, pw;
      rd  = 1'($urandom);
      phy = 5'($urandom);
      rg  = 5'($urandom);
      d   = 16'($urandom);
      pw  = 16'($urandom);
      run_cmd(rd, phy, rg, d, pw);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule